// File: doc/BRIEF.md
# Four-Lane Single-Precision Vector Maximum

This block takes two 128-bit vectors, each holding four IEEE-754 single-precision lanes, and returns the lane-wise maximum one clock after the operands are presented. It only selects between inputs: it does no arithmetic and no rounding, and it has no status or exception outputs. The vector is big-endian, so lane 0 is the most significant word.

Two controls shape the result. The NaN-policy input is sampled with each operation. In pick mode a lane takes operand B unless A compares strictly greater; any comparison that involves a NaN counts as false. In architectural mode a NaN input is returned quieted, and a pair of zeros with opposite signs gives positive zero. A flush mode register, which is set after reset, turns denormal inputs into zeros of the same sign before they are compared. When it is clear, denormals are ordered by their exact value and are passed through unchanged.

The ordering is done with sign-magnitude integer logic, so the block contains no floating-point comparator. The result depends only on the input values. It therefore makes no difference whether the destination of an instruction is also one of its sources.

Top module: `vfmax4`

## Requirements
- R1: Lane k (k=0..3) occupies bits [127-32k:96-32k] of each vector, with lane 0 at [127:96]. For ordinary non-zero, non-NaN values, each result lane is A's lane when A > B and B's lane otherwise.
- R2: `res_valid` rises in the cycle after a cycle with `op_valid` high and is low otherwise. `res_vec` changes only after an accepted operation and holds its value while no operation is accepted. Both are 0 after reset.
- R3: With `nan_arch`=0, a lane in which either operand is a NaN (exponent 0xFF, fraction non-zero) returns B's lane bit-exact. This holds even when A is the NaN and B is a normal number.
- R4: With `nan_arch`=0, max(+0,-0) returns -0 (0x80000000) and max(-0,+0) returns +0 (0x00000000), because B is chosen whenever A > B is false.
- R5: With `nan_arch`=1, a lane with a NaN input returns that NaN with fraction bit 22 set. When both inputs are NaN, A's NaN is used.
- R6: With `nan_arch`=1, max(+0,-0) and max(-0,+0) both return 0x00000000, and max(-0,-0) returns 0x80000000.
- R7: The flush mode register is 1 after reset. A cycle with `mode_wr`=1 loads it from `mode_flush`, and the new value applies to operations accepted in later cycles.
- R8: With flush mode 1, a denormal input (exponent 0, fraction non-zero) is treated as a zero of its own sign, and a lane that selects it returns that signed zero.
- R9: With flush mode 0, denormals are ordered by their exact value, and a selected denormal is returned unchanged.
- R10: The ordering is correct across mixed signs, negative values (the larger magnitude is smaller) and ±infinity (0x7F800000 / 0xFF800000).
- R11: When A and B carry the same bits in a lane, the result lane is that value, so using one vector as both sources returns the vector itself (NaN lanes are still quieted in architectural mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Load the flush mode register this cycle |
| mode_flush | input | 1 | Value loaded into the flush mode register (1 = flush denormals) |
| nan_arch | input | 1 | NaN policy for this operation: 1 = propagate quiet NaN, 0 = pick B |
| op_valid | input | 1 | Operands valid; result presented next cycle |
| a_vec | input | 128 | Operand A, four FP32 lanes, lane 0 at the top |
| b_vec | input | 128 | Operand B, four FP32 lanes, lane 0 at the top |
| res_valid | output | 1 | Result valid |
| res_vec | output | 128 | Lane-wise maximum |

## Verification
Because there is one register stage, a faulty selection or NaN or zero rule shows up in `res_vec` one cycle after the offending operation, and it affects only the lane whose inputs fall in that class. A fault in the flush mode register is different. It stays hidden until a denormal reaches a lane, and from then on it corrupts every operation that has such an input. The bench therefore checks the reset value of that register with a denormal before any write to it, and again after each write. The NaN policy is sampled per operation, so a bad policy select shows only on lanes that have a NaN or a pair of zeros. The bench therefore mixes the two policies between consecutive operations.

// File: rtl/vfmax4.sv
module vfmax4 #(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_wr,
  input  logic                  mode_flush,
  input  logic                  nan_arch,
  input  logic                  op_valid,
  input  logic [LANES*32-1:0]   a_vec,
  input  logic [LANES*32-1:0]   b_vec,
  output logic                  res_valid,
  output logic [LANES*32-1:0]   res_vec
);
  localparam int EW = 32;
  localparam int VW = LANES * EW;
  localparam logic [EW-1:0] QBIT = 32'h0040_0000;

  logic          flush_q;
  logic [VW-1:0] nxt;

  function automatic logic [EW-1:0] flush_dn(input logic [EW-1:0] x, input logic fz);
    return (fz && x[30:23] == 8'h00) ? {x[31], 31'b0} : x;
  endfunction

  function automatic logic [EW-1:0] lane_max(input logic [EW-1:0] ar, input logic [EW-1:0] br,
                                             input logic fz, input logic arch);
    logic [EW-1:0] a, b, r;
    logic an, bn, az, bz, gt;
    a  = flush_dn(ar, fz);
    b  = flush_dn(br, fz);
    an = (&a[30:23]) && (|a[22:0]);
    bn = (&b[30:23]) && (|b[22:0]);
    az = (a[30:0] == 31'b0);
    bz = (b[30:0] == 31'b0);
    if (an || bn || (az && bz)) gt = 1'b0;
    else if (a[31] != b[31])    gt = b[31];
    else if (!a[31])            gt = a[30:0] > b[30:0];
    else                        gt = a[30:0] < b[30:0];
    if (arch && an)             r = a | QBIT;
    else if (arch && bn)        r = b | QBIT;
    else if (arch && az && bz)  r = {a[31] & b[31], 31'b0};
    else                        r = gt ? a : b;
    return r;
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int LO = EW * (LANES - 1 - i);
    assign nxt[LO +: EW] = lane_max(a_vec[LO +: EW], b_vec[LO +: EW], flush_q, nan_arch);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_q   <= 1'b1;
      res_valid <= 1'b0;
      res_vec   <= '0;
    end else begin
      if (mode_wr) flush_q <= mode_flush;
      res_valid <= op_valid;
      if (op_valid) res_vec <= nxt;
    end
  end

  logic [LANES-1:0] out_dn;
  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assign out_dn[i] = (res_vec[EW*i+23 +: 8] == 8'h00) && (res_vec[EW*i +: 23] != 23'b0);
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && $stable(res_vec)));
  a_r8_no_denorm_out: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && flush_q && !mode_wr) |=> (out_dn == '0));
  a_r5_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && nan_arch && (&a_vec[VW-2 -: 8]) && (|a_vec[VW-10:VW-32]))
      |=> (res_vec[VW-1 -: EW] == ($past(a_vec[VW-1 -: EW]) | QBIT)));
  a_r3_pick_b: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !nan_arch && (&b_vec[VW-2 -: 8]) && (|b_vec[VW-10:VW-32]))
      |=> (res_vec[VW-1 -: EW] == $past(b_vec[VW-1 -: EW])));
endmodule

// File: tb/vfmax4_tb.sv
module vfmax4_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_wr = 1'b0, mode_flush = 1'b0, nan_arch = 1'b0, op_valid = 1'b0;
  logic [127:0] a_vec = '0, b_vec = '0;
  logic         res_valid;
  logic [127:0] res_vec;

  int n_chk = 0, n_bad = 0;
  logic [127:0] exp_q[$];
  string        tag_q[$];
  logic         flush_m;
  logic [31:0]  lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  vfmax4 u_dut (.clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_flush(mode_flush),
    .nan_arch(nan_arch), .op_valid(op_valid), .a_vec(a_vec), .b_vec(b_vec),
    .res_valid(res_valid), .res_vec(res_vec));

  function automatic logic is_nan(input logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction

  function automatic logic [31:0] key(input logic [31:0] x);
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction

  function automatic logic [31:0] ref_lane(input logic [31:0] a0, input logic [31:0] b0,
                                           input logic fz, input logic arch);
    logic [31:0] a, b;
    logic zz;
    a = (fz && a0[30:23] == 0) ? (a0 & 32'h8000_0000) : a0;
    b = (fz && b0[30:23] == 0) ? (b0 & 32'h8000_0000) : b0;
    zz = (a[30:0] == 0) && (b[30:0] == 0);
    if (arch) begin
      if (is_nan(a)) return a | 32'h0040_0000;
      if (is_nan(b)) return b | 32'h0040_0000;
      if (zz) return (a[31] && b[31]) ? 32'h8000_0000 : 32'h0;
    end
    if (is_nan(a) || is_nan(b) || zz) return b;
    return (key(a) > key(b)) ? a : b;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [127:0] a, input logic [127:0] b, input logic arch, input string tag);
    logic [127:0] e;
    for (int k = 0; k < 4; k++)
      e[96-32*k +: 32] = ref_lane(a[96-32*k +: 32], b[96-32*k +: 32], flush_m, arch);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    a_vec = a; b_vec = b; nan_arch = arch; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic set_flush(input logic v);
    mode_wr = 1'b1; mode_flush = v;
    @(negedge clk);
    mode_wr = 1'b0;
    flush_m = v;
  endtask

  function automatic logic [31:0] pick_val(input logic [31:0] r);
    case (r[3:0])
      4'd0: return 32'h0000_0000;
      4'd1: return 32'h8000_0000;
      4'd2: return 32'h7F80_0000;
      4'd3: return 32'hFF80_0000;
      4'd4: return 32'h7FC0_0000 | {9'b0, r[26:4]};
      4'd5: return {1'b0, 8'h00, r[26:4]};
      4'd6: return {1'b1, 8'h00, r[26:4]};
      4'd7: return {r[31], 8'h00, 23'd1};
      default: return r;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2: unexpected res_valid, got %h expected none", res_vec);
      end else begin
        automatic logic [127:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, res_vec, e);
      end
    end
  end

  initial begin
    logic [127:0] ra, rb;
    logic [127:0] held;
    flush_m = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R2 reset valid", {127'b0, res_valid}, 128'b0);
    check("R2 reset data", res_vec, 128'b0);
    // R7: flush on by default: +denorm vs -0 -> +0 vs -0 pick -> -0
    send({32'h0000_0001, 32'h8000_0003, 32'h3F80_0000, 32'h0000_0010},
         {32'h8000_0000, 32'h0000_0000, 32'h0000_0005, 32'h0040_0000}, 1'b0, "R7 default flush");
    // R1
    send({32'h3F80_0000, 32'h4000_0000, 32'hC040_0000, 32'h40A0_0000},
         {32'h3F00_0000, 32'h4080_0000, 32'hBF80_0000, 32'h4000_0000}, 1'b0, "R1 ordinary");
    // R10
    send({32'h7F80_0000, 32'hFF80_0000, 32'hC000_0000, 32'h3F80_0000},
         {32'h7F7F_FFFF, 32'hFF7F_FFFF, 32'h3F80_0000, 32'hBF80_0000}, 1'b0, "R10 inf/sign");
    // R3
    send({32'h7FC0_0000, 32'h7F80_0001, 32'h3F80_0000, 32'hFFC0_1234},
         {32'h3F80_0000, 32'hC000_0000, 32'h7F80_0005, 32'h7F80_0000}, 1'b0, "R3 pick NaN");
    // R4
    send({32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000},
         {32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 32'h0000_0000}, 1'b0, "R4 pick zeros");
    // R5
    send({32'h7F80_0001, 32'h3F80_0000, 32'h7FA0_0000, 32'hFF80_0002},
         {32'h3F80_0000, 32'hFF80_0003, 32'h7F80_0004, 32'h7FC0_0000}, 1'b1, "R5 arch NaN");
    // R6
    send({32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000},
         {32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 32'h0000_0000}, 1'b1, "R6 arch zeros");
    // R8 flush: denorms on both sides
    send({32'h0000_0005, 32'h8000_0002, 32'h0000_0007, 32'h3F80_0000},
         {32'h0000_0003, 32'h8000_0007, 32'h8000_0000, 32'h0000_0009}, 1'b1, "R8 flush");
    // R11 aliasing
    ra = {32'h4120_0000, 32'hC2C8_0000, 32'h7FC0_0001, 32'h0000_0000};
    send(ra, ra, 1'b0, "R11 same operand");
    send(ra, ra, 1'b1, "R11 same operand arch");
    // R2: idle gap, result holds
    @(negedge clk);
    held = res_vec;
    repeat (3) @(negedge clk);
    check("R2 hold", res_vec, held);
    check("R2 idle valid", {127'b0, res_valid}, 128'b0);
    // R7/R9: flush off
    set_flush(1'b0);
    send({32'h0000_0005, 32'h8000_0002, 32'h0000_0007, 32'h8000_0001},
         {32'h0000_0003, 32'h8000_0007, 32'h8000_0000, 32'h0000_0000}, 1'b0, "R9 exact denorm");
    send({32'h0000_0001, 32'h807F_FFFF, 32'h0080_0000, 32'h8000_0000},
         {32'h8000_0001, 32'h8080_0000, 32'h007F_FFFF, 32'h0000_0001}, 1'b1, "R9 exact denorm arch");
    set_flush(1'b1);
    send({32'h0000_0005, 32'h8000_0002, 32'h0000_0007, 32'h8000_0001},
         {32'h0000_0003, 32'h8000_0007, 32'h8000_0000, 32'h0000_0000}, 1'b0, "R7 flush rewritten");
    // R1 sweep: back-to-back, mixed policies and flush modes
    for (int n = 0; n < 400; n++) begin
      if (n == 200) set_flush(1'b0);
      for (int k = 0; k < 4; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        ra[32*k +: 32] = pick_val(lfsr);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        rb[32*k +: 32] = pick_val(lfsr);
      end
      send(ra, rb, lfsr[5], "R1 sweep");
    end
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule